// File: doc/BRIEF.md
# Clause-22 Management Frame Engine

This block turns one 32-bit register write into a complete clause-22 station-management exchange with an external PHY. The 32-bit word carries every field of the frame at a fixed position. The engine first sends a run of preamble ones on the data pin, then shifts the word out MSB first, one bit per management clock period. While the frame is running, an idle flag is held low.

For a read operation, the engine stops driving the data line for the turnaround and data bit times. It samples the PHY's reply on each rising edge of the management clock and places the 16 returned bits in the low half of the same register, where software reads them once idle is high again. The management clock is made from the system clock by a divider, selected per frame. Frames start only while the port enable input is set.

Word layout, MSB first: bits 31:30 start code 01, bits 29:28 operation (01 write, 10 read), bits 27:23 PHY address, bits 22:18 register address, bits 17:16 turnaround 10, bits 15:0 data.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset, idle is 1, mdc is 0, mdioOe is 0 and the management register reads 0.
- R2: A register write made while idle and with portEnable set starts a frame: idle reads 0 from the next clock and stays 0 until the frame ends.
- R3: A frame is 64 mdc periods. The first 32 periods carry 1 with mdioOe high. The next 32 carry register bits 31 down to 0, in that order, one per period.
- R4: The mdc half-period is 2^(2+divSel) system clocks. divSel values 0,1,2,3 give division by 8, 16, 32 and 64. The setting is taken when the frame starts.
- R5: idle returns to 1 exactly 128·2^(2+divSel) clocks after the starting write.
- R6: When bits 29:28 equal 10 (read), mdioOe is 0 during the periods of register bits 17:0 (mdc periods 46 to 63). For any other code, mdioOe stays 1 for the whole frame.
- R7: On a read, mdioIn is sampled at each rising mdc edge of periods 48 to 63 and stored MSB first into register bits 15:0. Bits 31:16 keep the written value.
- R8: A register write while a frame is in progress is ignored. The frame on the pins and the final register value are unchanged by it.
- R9: A write while portEnable is 0 stores the word but starts no frame: idle stays 1 and mdc stays 0.
- R10: If portEnable falls during a frame, the frame is abandoned. From the next clock, idle is 1, mdc is 0 and mdioOe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for the management register |
| regWrData | input | 32 | Word to write (frame fields) |
| portEnable | input | 1 | Management port enable |
| divSel | input | 2 | Management clock divider select |
| mgmtReg | output | 32 | Management register readback, reply in 15:0 after a read |
| idle | output | 1 | High when no frame is in progress |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data line output value |
| mdioOe | output | 1 | Data line output enable |
| mdioIn | input | 1 | Data line input from the PHY |

## Verification
A wrong bit counter or divider shows on the pins within one frame. The number of mdc rising edges or their spacing departs from 64 and 2^(3+divSel), and the busy time moves away from 128 half-periods. A wrong shift index or output-enable window shows within the first few periods after the preamble, as a mismatched bit or a driven turnaround. A capture fault shows in the readback as soon as idle returns. A busy-write or abort fault changes the frame bits, or the idle state, within a clock of the stimulus.

// File: rtl/mgmt_frame_pkg.sv
package mgmt_frame_pkg;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned PREAMBLE_LEN = 32;
  localparam int unsigned TOTAL_BITS   = PREAMBLE_LEN + WORD_W;
  localparam int unsigned BIT_W        = $clog2(TOTAL_BITS);
  localparam int unsigned IDX_W        = $clog2(WORD_W);
  localparam int unsigned DATA_W       = 16;
  // mdc period index where the turnaround and the data begin
  localparam int unsigned TA_START     = TOTAL_BITS - DATA_W - 2;
  localparam int unsigned DATA_START   = TOTAL_BITS - DATA_W;
  localparam int unsigned OP_HI        = 29;
  localparam int unsigned OP_LO        = 28;
  localparam logic [1:0]  OP_READ      = 2'b10;
  localparam logic [1:0]  OP_WRITE     = 2'b01;

  typedef struct packed {
    logic             active;
    logic             load;
    logic             capture;
    logic [BIT_W-1:0] bitIdx;
  } mgmt_strobe_t;
endpackage

// File: rtl/mgmt_frame_ctrl.sv
module mgmt_frame_ctrl
  import mgmt_frame_pkg::*;
#(
  parameter int unsigned DIV_BASE_SHIFT = 2,
  parameter int unsigned DIVSEL_W       = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                portEnable,
  input  logic [DIVSEL_W-1:0] divSel,
  output mgmt_strobe_t        strb,
  output logic                mdc,
  output logic                idle
);
  localparam int unsigned CNT_W = DIV_BASE_SHIFT + (2 ** DIVSEL_W) - 1;

  logic                running;
  logic                mdcQ;
  logic [CNT_W-1:0]    divCnt;
  logic [BIT_W-1:0]    bitIdx;
  logic [DIVSEL_W-1:0] divSelQ;
  logic [CNT_W-1:0]    halfLast;
  logic                halfDone;

  always_comb begin
    halfLast = CNT_W'((32'd1 << (DIV_BASE_SHIFT + 32'(divSelQ))) - 32'd1);
    halfDone = (divCnt == halfLast);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      mdcQ    <= 1'b0;
      divCnt  <= '0;
      bitIdx  <= '0;
      divSelQ <= '0;
    end else if (!running) begin
      if (regWrEn && portEnable) begin
        running <= 1'b1;
        mdcQ    <= 1'b0;
        divCnt  <= '0;
        bitIdx  <= '0;
        divSelQ <= divSel;
      end
    end else if (!portEnable) begin
      running <= 1'b0;
      mdcQ    <= 1'b0;
      divCnt  <= '0;
    end else if (halfDone) begin
      divCnt <= '0;
      if (!mdcQ) begin
        mdcQ <= 1'b1;
      end else begin
        mdcQ <= 1'b0;
        if (bitIdx == BIT_W'(TOTAL_BITS - 1)) running <= 1'b0;
        else bitIdx <= bitIdx + 1'b1;
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    strb.active  = running;
    strb.load    = !running && regWrEn;
    strb.capture = running && portEnable && !mdcQ && halfDone;
    strb.bitIdx  = bitIdx;
    mdc          = mdcQ;
    idle         = !running;
  end

  a_r2_start_goes_busy: assert property (@(posedge clk) disable iff (!rstN)
    (idle && regWrEn && portEnable) |=> !idle);
  a_r9_disabled_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (idle && !portEnable) |=> (idle && !mdc));
  a_r10_abort_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!idle && !portEnable) |=> (idle && !mdc));
endmodule

// File: rtl/mgmt_frame_datapath.sv
module mgmt_frame_datapath
  import mgmt_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mgmt_strobe_t      strb,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              mdioIn,
  output logic [WORD_W-1:0] mgmtReg,
  output logic              mdioOut,
  output logic              mdioOe
);
  logic             isRead;
  logic [IDX_W-1:0] wordIdx;
  logic             inPreamble;

  always_comb begin
    isRead     = (mgmtReg[OP_HI:OP_LO] == OP_READ);
    wordIdx    = IDX_W'(WORD_W - 1) - IDX_W'(strb.bitIdx);
    inPreamble = (strb.bitIdx < BIT_W'(PREAMBLE_LEN));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mgmtReg <= '0;
    end else if (strb.load) begin
      mgmtReg <= wrData;
    end else if (strb.capture && isRead && (strb.bitIdx >= BIT_W'(DATA_START))) begin
      mgmtReg[wordIdx] <= mdioIn;
    end
  end

  always_comb begin
    mdioOe  = strb.active && !(isRead && (strb.bitIdx >= BIT_W'(TA_START)));
    mdioOut = (!strb.active || inPreamble) ? 1'b1 : mgmtReg[wordIdx];
  end

  a_r7_upper_half_kept: assert property (@(posedge clk) disable iff (!rstN)
    strb.active |=> $stable(mgmtReg[WORD_W-1:DATA_W]));
  a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && wrEn && !strb.capture) |=> $stable(mgmtReg));
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
  import mgmt_frame_pkg::*;
#(
  parameter int unsigned DIV_BASE_SHIFT = 2,
  parameter int unsigned DIVSEL_W       = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [31:0]         regWrData,
  input  logic                portEnable,
  input  logic [DIVSEL_W-1:0] divSel,
  output logic [31:0]         mgmtReg,
  output logic                idle,
  output logic                mdc,
  output logic                mdioOut,
  output logic                mdioOe,
  input  logic                mdioIn
);
  mgmt_strobe_t strb;

  mgmt_frame_ctrl #(
    .DIV_BASE_SHIFT(DIV_BASE_SHIFT),
    .DIVSEL_W      (DIVSEL_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .portEnable(portEnable),
    .divSel    (divSel),
    .strb      (strb),
    .mdc       (mdc),
    .idle      (idle)
  );

  mgmt_frame_datapath dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrEn   (regWrEn),
    .wrData (regWrData),
    .mdioIn (mdioIn),
    .mgmtReg(mgmtReg),
    .mdioOut(mdioOut),
    .mdioOe (mdioOe)
  );
endmodule

// File: tb/mdio_mgmt_engine_tb.sv
module mdio_mgmt_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic        portEnable = 1'b0;
  logic [1:0]  divSel = '0;
  logic [31:0] mgmtReg;
  logic        idle, mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  always #4 clk = ~clk;

  mdio_mgmt_engine dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .portEnable(portEnable), .divSel(divSel), .mgmtReg(mgmtReg), .idle(idle),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int nCmp = 0;
  int nBad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // PHY-side model: records each rising mdc edge and presents reply bits
  logic [15:0] curReply = '0;
  logic        outBits [64];
  logic        oeBits  [64];
  int          riseTime[64];
  int          riseCnt = 0;
  int          cyc = 0;
  logic        prevMdc = 1'b0;

  function automatic logic replyBit(input int k);
    if (k >= 48 && k < 64) return curReply[63-k];
    if (k == 46 || k == 47) return 1'b0;
    return 1'b1;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (mdc && !prevMdc) begin
      if (riseCnt < 64) begin
        outBits[riseCnt]  = mdioOut;
        oeBits[riseCnt]   = mdioOe;
        riseTime[riseCnt] = cyc;
      end
      riseCnt++;
      mdioIn = replyBit(riseCnt);
    end
    prevMdc = mdc;
  end

  // one frame; optionally inject a write at busy cycle injAt
  task automatic runFrame(input logic [1:0] ds, input logic [31:0] word,
                          input logic [15:0] reply, input int injAt,
                          input logic [31:0] injWord, input string tag);
    int busy;
    int half;
    logic [31:0] expReg;
    logic rd;
    half = 1 << (2 + ds);
    rd = (word[29:28] == 2'b10);
    expReg = rd ? {word[31:16], reply} : word;
    @(negedge clk);
    divSel = ds; regWrData = word; regWrEn = 1'b1;
    curReply = reply; riseCnt = 0; mdioIn = replyBit(0);
    @(negedge clk);
    regWrEn = 1'b0;
    chk(idle == 1'b0, {"R2 busy after write ", tag}, 32'(idle), 32'd0);
    busy = 1;
    forever begin
      @(negedge clk);
      if (busy == injAt) begin regWrData = injWord; regWrEn = 1'b1; end
      else regWrEn = 1'b0;
      if (idle) break;
      busy++;
    end
    regWrEn = 1'b0;
    chk(busy == 128 * half, {"R5 busy length ", tag}, 32'(busy), 32'(128 * half));
    chk(riseCnt == 64, {"R3 mdc period count ", tag}, 32'(riseCnt), 32'd64);
    chk(riseTime[1] - riseTime[0] == 2 * half, {"R4 mdc period ", tag},
        32'(riseTime[1] - riseTime[0]), 32'(2 * half));
    begin
      int badOut = -1;
      int badOe = -1;
      for (int k = 0; k < 64; k++) begin
        logic eOut, eOe;
        eOut = (k < 32) ? 1'b1 : word[63-k];
        eOe  = !(rd && k >= 46);
        if (eOe && outBits[k] !== eOut && badOut < 0) badOut = k;
        if (oeBits[k] !== eOe && badOe < 0) badOe = k;
      end
      chk(badOut < 0, {"R3 frame bits ", tag}, 32'(badOut), 32'hFFFFFFFF);
      chk(badOe < 0, {"R6 output enable window ", tag}, 32'(badOe), 32'hFFFFFFFF);
    end
    chk(mgmtReg == expReg, {"R7 register after frame ", tag}, mgmtReg, expReg);
  endtask

  // divSel, word, reply
  localparam logic [49:0] VEC [4] = '{
    {2'd2, {2'b01, 2'b01, 5'd1,  5'd0,  2'b10, 16'hABCD}, 16'h0000},
    {2'd0, {2'b01, 2'b10, 5'd31, 5'd1,  2'b10, 16'h0000}, 16'h796D},
    {2'd3, {2'b01, 2'b10, 5'd5,  5'd2,  2'b10, 16'h5555}, 16'h8001},
    {2'd1, {2'b01, 2'b01, 5'd18, 5'd31, 2'b10, 16'h0000}, 16'h1234}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nCmp++; nBad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(idle == 1'b1, "R1 idle after reset", 32'(idle), 32'd1);
    chk(mdc == 1'b0, "R1 mdc after reset", 32'(mdc), 32'd0);
    chk(mdioOe == 1'b0, "R1 oe after reset", 32'(mdioOe), 32'd0);
    chk(mgmtReg == 32'd0, "R1 register after reset", mgmtReg, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R9 write while disabled
    begin
      bit stayedIdle = 1'b1;
      regWrData = 32'h6ACE_1234; regWrEn = 1'b1; riseCnt = 0;
      @(negedge clk);
      regWrEn = 1'b0;
      repeat (100) begin
        @(negedge clk);
        if (!idle || mdc) stayedIdle = 1'b0;
      end
      chk(stayedIdle, "R9 no frame while disabled", 32'(stayedIdle), 32'd1);
      chk(riseCnt == 0, "R9 no mdc edges while disabled", 32'(riseCnt), 32'd0);
      chk(mgmtReg == 32'h6ACE_1234, "R9 word stored while disabled", mgmtReg, 32'h6ACE_1234);
    end
    portEnable = 1'b1;

    // vector table: R2..R7
    for (int v = 0; v < 4; v++) begin
      runFrame(VEC[v][49:48], VEC[v][47:16], VEC[v][15:0], -1, '0, $sformatf("vec%0d", v));
    end

    // R8 write during a busy read frame is ignored
    runFrame(2'd0, {2'b01, 2'b10, 5'd3, 5'd4, 2'b10, 16'h0000}, 16'hC3A5, 150,
             32'h5FFF_FFFF, "R8 busy write");

    // R10 abort mid-frame
    @(negedge clk);
    divSel = 2'd1; regWrData = {2'b01, 2'b01, 5'd2, 5'd3, 2'b10, 16'hFFFF}; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    repeat (60) @(negedge clk);
    chk(idle == 1'b0, "R10 busy before abort", 32'(idle), 32'd0);
    portEnable = 1'b0;
    @(negedge clk);
    chk(idle == 1'b1, "R10 idle after abort", 32'(idle), 32'd1);
    chk(mdc == 1'b0, "R10 mdc low after abort", 32'(mdc), 32'd0);
    chk(mdioOe == 1'b0, "R10 oe low after abort", 32'(mdioOe), 32'd0);
    portEnable = 1'b1;

    // after abort a fresh frame still runs cleanly
    runFrame(2'd0, {2'b01, 2'b10, 5'd9, 5'd9, 2'b10, 16'h0000}, 16'h0F0F, -1, '0, "post-abort");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule